// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is a device-side model of a byte-wide parallel flash part as the host sees it across its write and read cycles. Each bus write is taken as a command byte, or as the second cycle of a two-cycle command. Each read returns one of three views, chosen by the current read mode: the storage array, the identification space, or the status byte.

Byte program and block erase behave as multi-cycle busy operations. While one is running, every read returns status with the ready bit low, and every write is dropped. Each block carries a lock bit, and a master lock can forbid clearing those lock bits. A host flow built around this block writes a command, polls status until the ready bit is set, and then clears the error bits.

Top module: `fwcmd_flash`

## Requirements
- R1: After reset the read mode is array, every array byte reads 0xFF, and a status read returns 0x80.
- R2: A write of 0xFF selects array reads, 0x90 selects identification reads and 0x70 selects status reads. In identification mode the in-block offset picks the value: 0 gives MFR_CODE, 1 gives DEV_CODE, 2 gives 0x01 or 0x00 for the lock bit of the addressed block, 3 gives 0x01 or 0x00 for the master lock. Any other offset gives 0x00.
- R3: With ADDR_SHIFT set to 1, the identification offset is the in-block address shifted right by one. Address 2 then reads DEV_CODE and address 6 reads the master lock.
- R4: A write of 0x50 clears status bits 5, 4 and 1.
- R5: 0x40 followed by a data write programs the byte at that write's address to old AND data, then starts a busy operation.
- R6: 0x20 followed by 0xD0, with the confirm written inside the target block, sets every byte of that block to 0xFF and leaves all other blocks unchanged.
- R7: A program or erase aimed at a locked block does not go busy and leaves the array unchanged. Status then reads 0x92 for a program and 0xA2 for an erase.
- R8: 0x60 followed by 0xD0 clears all block lock bits when the master lock is 0. When the master lock is 1, the lock bits stay unchanged and status bits 5 and 1 are set.
- R9: An erase or lock-clear confirm cycle whose data is not 0xD0 changes nothing, sets status bits 5 and 4, and leaves status mode selected.
- R10: An accepted program, erase or lock clear keeps the block busy for exactly BUSY_CYC cycles. During that time reads return status with bit 7 at 0, and writes have no effect. Afterwards status mode is selected.
- R11: Status bit 7 is 1 whenever no operation is running. Bits 6, 3, 2 and 0 always read 0.
- R12: A write of an unrecognised command byte leaves the read mode and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data or command byte |
| bus_rdata | output | 8 | Read data for bus_addr in the current mode |

## Verification
The assertions check the following on every cycle:
- a program can only clear bits;
- an accepted erase leaves the addressed byte at 0xFF;
- an attempt on a locked block fails without going busy, with the matching error bits set;
- a bad confirm sets both error bits;
- the lock bits move only on an accepted lock clear;
- writes made during busy leave the error state and any pending command alone.

Only the bench scenarios can show the things that need a view across many cycles or across the whole array: the exact busy length, the identification values under both address layouts, an erase leaving the other blocks intact, and the full status codes read back after each error case.

// File: rtl/fwcmd_pkg.sv
// Package: shared read modes, pending-command states and command bytes.
// Assumes byte-wide commands on the data bus.
package fwcmd_pkg;
    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rmode_t;

    typedef enum logic [1:0] {
        PD_NONE   = 2'd0,
        PD_PROG   = 2'd1,
        PD_ERASE  = 2'd2,
        PD_UNLOCK = 2'd3
    } pend_t;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_UNLOCK  = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
endpackage

// File: rtl/fwcmd_decoder.sv
// Command decoder: tracks the read mode, a pending two-cycle command,
// the busy countdown and the sticky error bits, and issues one-cycle
// enables to the array and the lock bank.
// Assumes lock_hit refers to the block addressed by the current write.
module fwcmd_decoder
    import fwcmd_pkg::*;
#(
    parameter int BUSY_CYC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       lock_hit,
    input  logic       master_lock,
    output rmode_t     mode,
    output logic       busy,
    output logic [7:0] status,
    output logic       prog_en,
    output logic       erase_en,
    output logic       unlock_en
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

    pend_t            pend;
    logic [CNT_W-1:0] cnt;
    logic             err_erase, err_prog, err_lock;
    logic             accept, confirm_ok;

    // Purpose: a write is accepted only while idle.
    assign accept     = we && (cnt == '0);
    assign confirm_ok = (wdata == CMD_CONFIRM);
    assign busy       = (cnt != '0);

    // Purpose: one-cycle enables for the operations that go ahead.
    assign prog_en   = accept && (pend == PD_PROG) && !lock_hit;
    assign erase_en  = accept && (pend == PD_ERASE) && confirm_ok && !lock_hit;
    assign unlock_en = accept && (pend == PD_UNLOCK) && confirm_ok && !master_lock;

    // Purpose: assemble the status byte; suspend and voltage flags stay 0.
    assign status = {~busy, 1'b0, err_erase, err_prog, 1'b0, 1'b0, err_lock, 1'b0};

    // Purpose: command sequencing, busy countdown and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= RM_ARRAY;
            pend      <= PD_NONE;
            cnt       <= '0;
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            err_lock  <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (we) begin
            unique case (pend)
                PD_PROG: begin
                    pend <= PD_NONE;
                    mode <= RM_STATUS;
                    if (lock_hit) begin
                        err_prog <= 1'b1;
                        err_lock <= 1'b1;
                    end else begin
                        cnt <= CNT_LOAD;
                    end
                end
                PD_ERASE: begin
                    pend <= PD_NONE;
                    mode <= RM_STATUS;
                    if (!confirm_ok) begin
                        err_erase <= 1'b1;
                        err_prog  <= 1'b1;
                    end else if (lock_hit) begin
                        err_erase <= 1'b1;
                        err_lock  <= 1'b1;
                    end else begin
                        cnt <= CNT_LOAD;
                    end
                end
                PD_UNLOCK: begin
                    pend <= PD_NONE;
                    mode <= RM_STATUS;
                    if (!confirm_ok) begin
                        err_erase <= 1'b1;
                        err_prog  <= 1'b1;
                    end else if (master_lock) begin
                        err_erase <= 1'b1;
                        err_lock  <= 1'b1;
                    end else begin
                        cnt <= CNT_LOAD;
                    end
                end
                default: begin
                    case (wdata)
                        CMD_ARRAY:  mode <= RM_ARRAY;
                        CMD_IDENT:  mode <= RM_IDENT;
                        CMD_STATUS: mode <= RM_STATUS;
                        CMD_CLRSTAT: begin
                            err_erase <= 1'b0;
                            err_prog  <= 1'b0;
                            err_lock  <= 1'b0;
                        end
                        CMD_ERASE: begin
                            pend <= PD_ERASE;
                            mode <= RM_STATUS;
                        end
                        CMD_PROG: begin
                            pend <= PD_PROG;
                            mode <= RM_STATUS;
                        end
                        CMD_UNLOCK: begin
                            pend <= PD_UNLOCK;
                            mode <= RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    // R7: a program into a locked block fails at once with bits 4 and 1 set
    a_r7_locked_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pend == PD_PROG && lock_hit) |=> (!busy && err_prog && err_lock));

    // R9: a confirm byte other than 0xD0 sets both error bits
    a_r9_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (pend == PD_ERASE || pend == PD_UNLOCK) && !confirm_ok)
        |=> (err_erase && err_prog && mode == RM_STATUS && pend == PD_NONE));

    // R10: writes made while busy change neither errors nor pending state
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we) |=> ($stable(err_erase) && $stable(err_prog)
                          && $stable(err_lock) && $stable(pend) && $stable(mode)));
endmodule

// File: rtl/fwcmd_array.sv
// Storage array: byte-addressed cells that reset to 0xFF. A program
// enable ANDs data into one byte; an erase enable fills the whole block
// that holds the given address with 0xFF.
// Assumes at most one enable per cycle.
module fwcmd_array #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BLK_BYTES = 1 << BLK_W;
    localparam int NBLK_W    = ADDR_W - BLK_W;

    logic [7:0]        mem [DEPTH];
    logic [7:0]        cell_now;
    logic [NBLK_W-1:0] wr_blk;

    assign wr_blk   = wr_addr[ADDR_W-1:BLK_W];
    assign cell_now = mem[wr_addr];
    assign rd_data  = mem[rd_addr];

    // Purpose: reset to erased, then apply program or block erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int j = 0; j < BLK_BYTES; j++)
                mem[{wr_blk, BLK_W'(j)}] <= 8'hFF;
        end else if (prog_en) begin
            mem[wr_addr] <= cell_now & wr_data;
        end
    end

    // R5: a program never turns a 0 bit into 1
    a_r5_prog_clears_only: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem[$past(wr_addr)] & ~$past(cell_now)) == 8'h00));

    // R6: after an erase the addressed byte reads 0xFF
    a_r6_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[$past(wr_addr)] == 8'hFF));
endmodule

// File: rtl/fwcmd_lockbank.sv
// Lock bank: one lock bit per block, loaded from LOCK_INIT at reset and
// cleared together by an accepted lock-clear operation.
// Assumes the master lock is a fixed parameter.
module fwcmd_lockbank #(
    parameter int NBLK = 4,
    parameter logic [NBLK-1:0] LOCK_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            unlock_en,
    output logic [NBLK-1:0] locks
);
    // Purpose: hold the lock bits; clear all of them on an unlock enable.
    always_ff @(posedge clk) begin
        if (!rst_n)         locks <= LOCK_INIT;
        else if (unlock_en) locks <= '0;
    end

    // R8: lock bits change only on an accepted lock clear
    a_r8_locks_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_en |=> $stable(locks));
endmodule

// File: rtl/fwcmd_flash.sv
// Top level: ties the decoder, array and lock bank together and selects
// the read data for the current mode. Reads are combinational from
// bus_addr; during busy every read returns status.
// Assumes one bus write per cycle at most.
module fwcmd_flash
    import fwcmd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BLK_W       = 6,
    parameter int BUSY_CYC    = 5,
    parameter logic [7:0] MFR_CODE = 8'h89,
    parameter logic [7:0] DEV_CODE = 8'hA6,
    parameter int ADDR_SHIFT  = 0,
    parameter bit MASTER_LOCK = 1'b0,
    parameter logic [(1 << (ADDR_W - BLK_W))-1:0] LOCK_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int NBLK_W = ADDR_W - BLK_W;
    localparam int NBLK   = 1 << NBLK_W;

    rmode_t            mode;
    logic              busy, prog_en, erase_en, unlock_en, lock_hit;
    logic [7:0]        status, arr_data, id_data;
    logic [NBLK-1:0]   locks;
    logic [NBLK_W-1:0] blk;
    logic [BLK_W-1:0]  id_off;

    assign blk      = bus_addr[ADDR_W-1:BLK_W];
    assign lock_hit = locks[blk];
    assign id_off   = bus_addr[BLK_W-1:0] >> ADDR_SHIFT;

    fwcmd_decoder #(.BUSY_CYC(BUSY_CYC)) u_dec (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .wdata(bus_wdata),
        .lock_hit(lock_hit), .master_lock(MASTER_LOCK),
        .mode(mode), .busy(busy), .status(status),
        .prog_en(prog_en), .erase_en(erase_en), .unlock_en(unlock_en)
    );

    fwcmd_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .erase_en(erase_en),
        .wr_addr(bus_addr), .wr_data(bus_wdata),
        .rd_addr(bus_addr), .rd_data(arr_data)
    );

    fwcmd_lockbank #(.NBLK(NBLK), .LOCK_INIT(LOCK_INIT)) u_lock (
        .clk(clk), .rst_n(rst_n), .unlock_en(unlock_en), .locks(locks)
    );

    // Purpose: identification space decode by in-block offset.
    always_comb begin
        case (id_off)
            BLK_W'(0): id_data = MFR_CODE;
            BLK_W'(1): id_data = DEV_CODE;
            BLK_W'(2): id_data = {7'd0, lock_hit};
            BLK_W'(3): id_data = {7'd0, MASTER_LOCK};
            default:   id_data = 8'h00;
        endcase
    end

    // Purpose: read data select; busy forces status.
    always_comb begin
        if (busy || mode == RM_STATUS) bus_rdata = status;
        else if (mode == RM_IDENT)     bus_rdata = id_data;
        else                           bus_rdata = arr_data;
    end
endmodule

// File: tb/fwcmd_flash_test.sv
module fwcmd_flash_test;
    localparam int BUSY = 5;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0, we2 = 1'b0;
    logic [7:0] addr = '0, wd = '0, rdat;
    logic [7:0] addr2 = '0, wd2 = '0, rdat2;
    int checks = 0, errors = 0;
    logic [7:0] mdl [256];

    always #4 clk = ~clk;

    fwcmd_flash #(.BUSY_CYC(BUSY), .LOCK_INIT(4'b0100)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wd), .bus_rdata(rdat));

    fwcmd_flash #(.BUSY_CYC(BUSY), .ADDR_SHIFT(1), .MASTER_LOCK(1'b1),
                  .LOCK_INIT(4'b0001)) uut_sh (
        .clk(clk), .rst_n(rst_n), .bus_we(we2), .bus_addr(addr2),
        .bus_wdata(wd2), .bus_rdata(rdat2));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wd = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a; #2; v = rdat;
        @(negedge clk);
    endtask

    task automatic wr2(input logic [7:0] a, input logic [7:0] d);
        addr2 = a; wd2 = d; we2 = 1'b1;
        @(negedge clk);
        we2 = 1'b0;
    endtask

    task automatic rd2(input logic [7:0] a, output logic [7:0] v);
        addr2 = a; #2; v = rdat2;
        @(negedge clk);
    endtask

    // Count the busy reads until status shows ready.
    task automatic wait_ready(output int n, output logic [7:0] st);
        n = 0;
        for (int k = 0; k < 100; k++) begin
            rd(8'h00, st);
            if (st[7]) break;
            n++;
        end
    endtask

    function automatic logic [7:0] prog_exp(input logic [7:0] old, input logic [7:0] d);
        return old & d;
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, v); chk("R1 array after reset", v, 8'hFF);
        wr(8'h00, 8'h70); rd(8'h00, v); chk("R1 R11 status after reset", v, 8'h80);

        // R2 identification reads
        wr(8'h00, 8'h90);
        rd(8'h00, v); chk("R2 mfr", v, 8'h89);
        rd(8'h01, v); chk("R2 dev", v, 8'hA6);
        rd(8'h42, v); chk("R2 block1 lock", v, 8'h00);
        rd(8'h82, v); chk("R2 block2 lock", v, 8'h01);
        rd(8'h03, v); chk("R2 master lock", v, 8'h00);
        rd(8'h05, v); chk("R2 other offset", v, 8'h00);
        // R12 unknown opcode ignored
        wr(8'h00, 8'h33); rd(8'h40, v); chk("R12 mode kept", v, 8'h89);
        wr(8'h00, 8'hFF); rd(8'h00, v); chk("R2 back to array", v, 8'hFF);

        // R3 shifted layout on the second instance
        wr2(8'h00, 8'h90);
        rd2(8'h00, v); chk("R3 mfr", v, 8'h89);
        rd2(8'h02, v); chk("R3 dev", v, 8'hA6);
        rd2(8'h04, v); chk("R3 block0 lock", v, 8'h01);
        rd2(8'h06, v); chk("R3 master lock", v, 8'h01);

        // R5 R10 random programs outside locked block 2
        for (int it = 0; it < 30; it++) begin
            logic [7:0] a, d;
            a = 8'($urandom_range(0, 255));
            if (a[7:6] == 2'b10) a[7:6] = 2'b11;
            d = 8'($urandom);
            wr(a, 8'h40); wr(a, d);
            mdl[a] = prog_exp(mdl[a], d);
            wait_ready(n, v);
            if (it < 3) begin
                checks++;
                if (n != BUSY) begin
                    errors++;
                    $display("FAIL R10 busy length actual=%0d expected=%0d", n, BUSY);
                end
            end
            chk("R5 ready status", v, 8'h80);
            wr(8'h00, 8'hFF); rd(a, v); chk("R5 programmed byte", v, mdl[a]);
        end

        // R10 writes during busy are ignored
        wr(8'h07, 8'h40); wr(8'h07, 8'h5A); mdl[7] = prog_exp(mdl[7], 8'h5A);
        rd(8'h00, v); chk("R10 busy status", v, 8'h00);
        wr(8'h00, 8'h90); wr(8'h00, 8'h50);
        wait_ready(n, v); chk("R10 status mode kept", v, 8'h80);
        wr(8'h00, 8'hFF); rd(8'h07, v); chk("R10 program done", v, mdl[7]);

        // R6 erase block 1 only
        wr(8'h45, 8'h20); wr(8'h45, 8'hD0);
        for (int i = 64; i < 128; i++) mdl[i] = 8'hFF;
        wait_ready(n, v); chk("R6 ready", v, 8'h80);
        wr(8'h00, 8'hFF);
        for (int i = 0; i < 256; i += 9) begin
            rd(8'(i), v); chk("R6 array after erase", v, mdl[i]);
        end

        // R7 locked block
        wr(8'h90, 8'h40); wr(8'h90, 8'h00);
        rd(8'h00, v); chk("R7 locked program status", v, 8'h92);
        wr(8'h00, 8'h50); rd(8'h00, v); chk("R4 clear status", v, 8'h80);
        wr(8'h88, 8'h20); wr(8'h88, 8'hD0);
        rd(8'h00, v); chk("R7 locked erase status", v, 8'hA2);
        wr(8'h00, 8'hFF); rd(8'h90, v); chk("R7 array unchanged", v, 8'hFF);
        wr(8'h00, 8'h50);

        // R9 bad confirm
        wr(8'h05, 8'h40); wr(8'h05, 8'h0F); mdl[5] = prog_exp(mdl[5], 8'h0F);
        wait_ready(n, v);
        wr(8'h05, 8'h20); wr(8'h05, 8'h11);
        rd(8'h00, v); chk("R9 abort status", v, 8'hB0);
        wr(8'h00, 8'hFF); rd(8'h05, v); chk("R9 array unchanged", v, mdl[5]);
        wr(8'h00, 8'h50); wr(8'h00, 8'h70); rd(8'h00, v); chk("R4 cleared", v, 8'h80);

        // R8 lock clear, master unlocked
        wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
        wait_ready(n, v); chk("R8 unlock ready", v, 8'h80);
        wr(8'h00, 8'h90); rd(8'h82, v); chk("R8 lock cleared", v, 8'h00);
        wr(8'h90, 8'h40); wr(8'h90, 8'h3C);
        wait_ready(n, v); chk("R8 program after unlock", v, 8'h80);
        wr(8'h00, 8'hFF); rd(8'h90, v); chk("R8 byte programmed", v, 8'h3C);

        // R8 master locked on second instance
        wr2(8'h00, 8'h60); wr2(8'h00, 8'hD0);
        rd2(8'h00, v); chk("R8 master locked status", v, 8'hA2);
        wr2(8'h00, 8'h90); rd2(8'h04, v); chk("R8 lock kept", v, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule